// File: doc/BRIEF.md
# Rational Clock-Enable Tick Generator

This block turns a fast clock into a lower-rate enable pulse that stays in the same clock domain. Each enabled cycle, a fractional accumulator adds a programmable increment N. Whenever the sum reaches the modulus D, the block emits a one-cycle tick and takes D back off. Over any window of D enabled cycles that starts from reset, exactly N ticks come out. Individual tick spacings differ by at most one clock period.

A parameter picks the accumulator variant. The exact variant compares against a loaded modulus D and is exact for any ratio. The power-of-two variant is a plain W-bit binary accumulator: its carry is the tick, the modulus is fixed at 2^W, and D is not used. A second parameter makes the block one-shot, giving a single tick per reset. If that tick is fed back into the reset, the block runs as an oscillator with a fixed period. N and D are captured only while reset is held, so software or a neighbouring block loads the ratio by pulsing reset.

Top module: `rtg_tick_gen`

## Requirements
- R1: `tick_o` is registered and lasts exactly one cycle. With a loaded ratio 0 < N/D <= 1/2, it is never high in two consecutive cycles.
- R2: In exact mode, count the enabled non-reset cycles since reset as m = 1, 2, .... Cycle m produces a tick, seen on `tick_o` after that cycle's clock edge, exactly when floor(m*N/D) > floor((m-1)*N/D). Hence k*D enabled cycles give k*N ticks.
- R3: In exact mode with enable held high, consecutive ticks are either floor(D/N) or ceil(D/N) cycles apart.
- R4: While `en_i` is low and reset is low, the accumulator holds its value and `tick_o` stays low on the following cycle.
- R5: A synchronous reset overrides `en_i`. It clears the accumulator and drives `tick_o` low after the edge.
- R6: `num_i` and `den_i` are captured on every edge where `rst_i` is high. Changes to them while reset is low have no effect on the tick pattern.
- R7: In power-of-two mode, the tick of enabled cycle m is the carry out of the W-bit sum, so the tick rule of R2 applies with D = 2^W. `den_i` is ignored.
- R8: In one-shot mode, only the first tick after reset is produced. All later ticks are suppressed until the next reset.
- R9: In one-shot exact mode, if `tick_o` is ORed into `rst_i`, ticks repeat with a period of exactly ceil(D/N)+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; also loads the ratio |
| en_i | input | 1 | Cycle enable for the accumulator |
| num_i | input | W | Increment N, sampled during reset |
| den_i | input | W | Modulus D, sampled during reset (unused in power-of-two mode) |
| tick_o | output | 1 | One-cycle enable pulse |

## Verification
The exact variant is run with several ratios:
- 3/20, a ratio with an uneven spacing;
- 7/16, a ratio near one half;
- 5/17, a prime modulus;
- 1/2, the boundary.

Each run compares every cycle against the floor-difference rule and counts ticks over whole multiples of D. This separates an exact accumulator from one that drifts or rounds. A run with a periodic enable gap shows that disabled cycles neither advance the phase nor tick. A mid-run reset and input changes made outside reset show whether the state is really cleared and the ratio really frozen. A power-of-two instance and a one-shot instance, run both free and with feedback, separate the carry-based variant and the suppress-after-first-tick rule from the exact path.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic {
    RTG_EXACT = 1'b0,
    RTG_POW2  = 1'b1
  } rtg_mode_e;

  localparam int unsigned RTG_MAX_W = 48;
endpackage

// File: rtl/rtg_ratio_latch.sv
module rtg_ratio_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] num_o,
  output logic [W-1:0] den_o
);
  logic [W-1:0] num_q, den_q;

  // Ratio is taken only while reset is held.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      num_q <= num_i;
      den_q <= den_i;
    end
  end

  assign num_o = num_q;
  assign den_o = den_q;

  AST_RATIO_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> ($stable(num_q) && $stable(den_q))); // R6
endmodule

// File: rtl/rtg_accum.sv
module rtg_accum
  import rtg_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter rtg_mode_e   MODE = RTG_EXACT
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         hit_o
);
  generate
    if (MODE == RTG_EXACT) begin : g_exact
      localparam int unsigned AW = W + 1;
      logic [AW-1:0] acc_q, sum, nxt;

      always_comb begin
        sum   = acc_q + {1'b0, num_i};
        hit_o = (sum >= {1'b0, den_i});
        nxt   = hit_o ? (sum - {1'b0, den_i}) : sum;
      end

      always_ff @(posedge clk_i) begin
        if (rst_i)     acc_q <= '0;
        else if (en_i) acc_q <= nxt;
      end

      AST_ACC_BELOW_DEN: assert property (@(posedge clk_i) disable iff (rst_i)
        acc_q < {1'b0, den_i}); // R2
      AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(acc_q)); // R4
      AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (acc_q == '0)); // R5
    end else begin : g_pow2
      logic [W-1:0] acc_q, sum;
      logic         unused_den;

      assign unused_den      = ^den_i;
      assign {hit_o, sum}    = {1'b0, acc_q} + {1'b0, num_i};

      always_ff @(posedge clk_i) begin
        if (rst_i)     acc_q <= '0;
        else if (en_i) acc_q <= sum;
      end

      AST_P2_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(acc_q)); // R4
      AST_P2_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (acc_q == '0)); // R5
    end
  endgenerate
endmodule

// File: rtl/rtg_shot_gate.sv
module rtg_shot_gate #(
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic hit_i,
  output logic tick_o
);
  logic tick_q;
  logic done;

  generate
    if (ONE_SHOT) begin : g_once
      logic done_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)                        done_q <= 1'b0;
        else if (en_i && hit_i)           done_q <= 1'b1;
      end
      assign done = done_q;

      AST_SHOT_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |=> !tick_q); // R8
    end else begin : g_free
      assign done = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) tick_q <= 1'b0;
    else       tick_q <= en_i && hit_i && !done;
  end

  assign tick_o = tick_q;

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_q |=> !tick_q); // R1
  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !tick_q); // R4
endmodule

// File: rtl/rtg_tick_gen.sv
module rtg_tick_gen
  import rtg_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter rtg_mode_e   MODE     = RTG_EXACT,
  parameter bit          ONE_SHOT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         tick_o
);
  logic [W-1:0] num_l, den_l;
  logic         hit;

  rtg_ratio_latch #(.W(W)) ratio_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .num_i (num_i),
    .den_i (den_i),
    .num_o (num_l),
    .den_o (den_l)
  );

  rtg_accum #(.W(W), .MODE(MODE)) accum_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .num_i (num_l),
    .den_i (den_l),
    .hit_o (hit)
  );

  rtg_shot_gate #(.ONE_SHOT(ONE_SHOT)) gate_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .hit_i  (hit),
    .tick_o (tick_o)
  );

  initial begin
    if (W < 2 || W > RTG_MAX_W) $error("rtg_tick_gen: W out of range");
  end
endmodule

// File: tb/rtg_tick_gen_tb_top.sv
`timescale 1ns/1ps
module rtg_tick_gen_tb_top;
  import rtg_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // exact, free running
  logic        rst_a = 1'b1, en_a = 1'b0, tick_a;
  logic [15:0] num_a = 16'd3, den_a = 16'd20;
  // power of two, W=8
  logic        rst_b = 1'b1, en_b = 1'b0, tick_b;
  logic [7:0]  num_b = 8'd77, den_b = 8'd5;
  // exact, one shot
  logic        rst_c = 1'b1, en_c = 1'b0, fb_c = 1'b0, tick_c, rst_c_eff;
  logic [15:0] num_c = 16'd3, den_c = 16'd20;

  assign rst_c_eff = rst_c | (fb_c & tick_c);

  rtg_tick_gen #(.W(16), .MODE(RTG_EXACT), .ONE_SHOT(1'b0)) dut_i (
    .clk_i(clk), .rst_i(rst_a), .en_i(en_a), .num_i(num_a), .den_i(den_a), .tick_o(tick_a));
  rtg_tick_gen #(.W(8), .MODE(RTG_POW2), .ONE_SHOT(1'b0)) dut_p2_i (
    .clk_i(clk), .rst_i(rst_b), .en_i(en_b), .num_i(num_b), .den_i(den_b), .tick_o(tick_b));
  rtg_tick_gen #(.W(16), .MODE(RTG_EXACT), .ONE_SHOT(1'b1)) dut_os_i (
    .clk_i(clk), .rst_i(rst_c_eff), .en_i(en_c), .num_i(num_c), .den_i(den_c), .tick_o(tick_c));

  function automatic bit hit(input longint m, input longint n, input longint d);
    return ((m * n) / d) != (((m - 1) * n) / d);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic reset_a(input int n, input int d);
    @(negedge clk);
    rst_a = 1'b1; en_a = 1'b1; num_a = 16'(n); den_a = 16'(d);
    @(negedge clk);
    chk(tick_a === 1'b0, "R5", tick_a, 0, "tick after reset edge");
    rst_a = 1'b0;
  endtask

  // gap_mod=0: enable always on; otherwise enable dropped when i%gap_mod==2
  task automatic run_a(input int n, input int d, input int cycles, input int gap_mod,
                       input string req, output int ticks);
    int m = 0;
    int last = -1;
    bit en_prev = 1'b1;
    int lo = d / n;
    int hi = (d + n - 1) / n;
    ticks = 0;
    for (int i = 1; i <= cycles; i++) begin
      bit exp_t;
      @(negedge clk);
      if (en_prev) begin m++; exp_t = hit(m, n, d); end
      else exp_t = 1'b0;
      chk(tick_a === exp_t, req, tick_a, exp_t, "per-cycle tick");
      if (tick_a === 1'b1) begin
        ticks++;
        if (gap_mod == 0 && last >= 0) begin
          chk((i - last) >= lo && (i - last) <= hi, "R3", i - last, lo, "tick spacing");
          chk((i - last) >= 2, "R1", i - last, 2, "ticks back to back");
        end
        last = i;
      end
      en_prev = (gap_mod == 0) ? 1'b1 : ((i % gap_mod) != 2);
      en_a = en_prev;
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk(tick_a === 1'b0, "R5", tick_a, 0, "tick held in reset");
    chk(tick_c === 1'b0, "R5", tick_c, 0, "one-shot tick held in reset");
  endtask

  task automatic t_exact(input int n, input int d, input int k);
    int t;
    reset_a(n, d);
    run_a(n, d, k * d, 0, "R2", t);
    chk(t == k * n, "R2", t, k * n, "tick count over k*D");
  endtask

  task automatic t_enable_gaps;
    int t;
    reset_a(3, 20);
    run_a(3, 20, 150, 5, "R4", t);
    chk(t == 3 * 120 / 20, "R4", t, 18, "ticks over 120 enabled cycles");
  endtask

  task automatic t_mid_reset;
    int t;
    reset_a(3, 20);
    run_a(3, 20, 17, 0, "R2", t);
    reset_a(3, 20);
    run_a(3, 20, 20, 0, "R5", t);
    chk(t == 3, "R5", t, 3, "ticks after mid-run reset");
  endtask

  task automatic t_ignore_change;
    int t;
    reset_a(3, 20);
    num_a = 16'd7; den_a = 16'd16;
    run_a(3, 20, 60, 0, "R6", t);
    chk(t == 9, "R6", t, 9, "ticks with inputs changed outside reset");
  endtask

  task automatic t_pow2;
    int t = 0;
    @(negedge clk);
    rst_b = 1'b1; en_b = 1'b1; num_b = 8'd77; den_b = 8'd5;
    @(negedge clk);
    rst_b = 1'b0;
    for (int m = 1; m <= 256; m++) begin
      bit exp_t;
      @(negedge clk);
      exp_t = hit(m, 77, 256);
      chk(tick_b === exp_t, "R7", tick_b, exp_t, "carry tick");
      if (tick_b === 1'b1) t++;
    end
    chk(t == 77, "R7", t, 77, "ticks over 2^W cycles");
  endtask

  task automatic start_c(input bit fb);
    @(negedge clk);
    fb_c = fb; rst_c = 1'b1; en_c = 1'b1; num_c = 16'd3; den_c = 16'd20;
    @(negedge clk);
    rst_c = 1'b0;
  endtask

  task automatic t_one_shot;
    int t = 0;
    start_c(1'b0);
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      chk(tick_c === (i == 7), "R8", tick_c, (i == 7), "one-shot tick");
      if (tick_c === 1'b1) t++;
    end
    chk(t == 1, "R8", t, 1, "one-shot tick count");
  endtask

  task automatic t_feedback;
    int t = 0;
    start_c(1'b1);
    for (int i = 1; i <= 80; i++) begin
      bit exp_t;
      @(negedge clk);
      exp_t = (i >= 7) && (((i - 7) % 8) == 0);
      chk(tick_c === exp_t, "R9", tick_c, exp_t, "feedback period 8");
      if (tick_c === 1'b1) t++;
    end
    chk(t == 10, "R9", t, 10, "feedback tick count");
    @(negedge clk);
    fb_c = 1'b0; rst_c = 1'b1;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    t_reset_state();
    t_exact(3, 20, 5);
    t_exact(7, 16, 5);
    t_exact(5, 17, 10);
    t_exact(1, 2, 10);
    t_enable_gaps();
    t_mid_reset();
    t_ignore_change();
    t_pow2();
    t_one_shot();
    t_feedback();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule